// File: doc/BRIEF.md
# Per-Line GPIO Interrupt Capture Register

This block holds the interrupt state of a single general-purpose I/O line. It watches the line's conditioned input level, which has already been glitch-filtered and, where needed, inverted upstream. From that level it captures an interrupt status bit. It drives a level-sensitive interrupt request toward a message-signalled vector. Falling-edge and active-low interrupts are obtained upstream by inverting the pin. This block therefore only ever looks for rising edges or high levels.

Software reaches the line through one control word. Writes to that word carry four independent write-one command bits: clear status, set status, clear enable and set enable. A write can combine several of them, for example masking and acknowledging in one access. The line configuration supplies two static bits. One is an interrupt-enable bit that gates the request. The other is a trigger-type bit that selects edge or level capture. Address decoding happens outside the block, which sees only a write strobe, write data and a read-data word.

Top module: `gpio_line_irq`

## Requirements
- R1: After synchronous active-low reset the status bit and the enable flag are 0, the request output is 0 and the read word is all zeros.
- R2: With trigger type 1 (edge), a 0-to-1 change of the conditioned level sets status on the clock edge where the new level is sampled. A level that stays high does not set it again after a clear.
- R3: With trigger type 0 (level), status is set on every clock edge where the conditioned level is high, so a clear while the level is high leaves status at 1. A clear while the level is low drops it.
- R4: A write with data bit 0 set clears status at that clock edge, unless a set happens in the same cycle.
- R5: A write with data bit 1 set sets status. When bits 1 and 0 are both set in one write, status ends at 1.
- R6: A hardware capture (edge or level) in the same cycle as a status-clear write leaves status at 1.
- R7: Write data bit 3 sets the enable flag and bit 2 clears it, and set wins when both are present. One write with bits 2 and 0 clears both enable and status.
- R8: The request output equals status AND enable flag AND the configuration interrupt-enable input. Status capture continues while the request is gated off.
- R9: The read word carries status at bit 0 and the enable flag at bit 3, with every other bit 0.
- R10: Write data has no effect on status or enable while the write strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lvl_in | input | 1 | Filtered, polarity-adjusted line level |
| cfg_int_en | input | 1 | Line configuration: interrupt enable |
| cfg_edge | input | 1 | Line configuration: 1 edge trigger, 0 level trigger |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | REG_W (64) | Write data, bits 0..3 are write-one commands |
| rd_data | output | REG_W (64) | Read word: bit 0 status, bit 3 enable flag |
| irq_req | output | 1 | Active-high level interrupt request |

## Verification
A wrong status or enable flop shows at both outputs within the clock edge that follows the stimulus. The status bit and enable flag are visible in the read word, and their AND with the configuration enable drives the request. A priority error between set and clear shows up only in cycles where a capture and a clear write coincide, so the bench creates those collisions on purpose. A lost edge memory shows when a level stays high across a clear in edge mode. The reference model is compared against both outputs a quarter period after every rising edge.

// File: rtl/gpio_irq_pkg.sv
// Package: shared command bit positions and the decoded write command
// for the per-line interrupt capture register.
package gpio_irq_pkg;

    // Write-one command bit positions inside the control word.
    localparam int unsigned STS_CLR_BIT = 0;
    localparam int unsigned STS_SET_BIT = 1;
    localparam int unsigned ENA_CLR_BIT = 2;
    localparam int unsigned ENA_SET_BIT = 3;

    // Read-back bit positions.
    localparam int unsigned RD_STS_BIT  = 0;
    localparam int unsigned RD_ENA_BIT  = 3;

    // Lowest width that holds every command bit.
    localparam int unsigned MIN_REG_W   = 4;

    // Decoded write command, valid only in cycles with a write.
    typedef struct packed {
        logic ena_set;
        logic ena_clr;
        logic sts_set;
        logic sts_clr;
    } irq_cmd_t;

endpackage

// File: rtl/gpio_irq_trigger.sv
// Module: gpio_irq_trigger
// Turns the conditioned line level into a one-cycle-per-event hardware
// set pulse. Edge mode gives a pulse on a sampled 0-to-1 change. Level
// mode passes the level through.
// Assumes: lvl_in is already synchronous to clk and glitch filtered.
module gpio_irq_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_in,
    input  logic edge_mode,
    output logic hw_set
);

    logic lvl_prev;

    // Remember last sampled level for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_prev <= 1'b0;
        else        lvl_prev <= lvl_in;
    end

    // Select the capture condition for the configured trigger type.
    always_comb begin
        if (edge_mode) hw_set = lvl_in & ~lvl_prev;
        else           hw_set = lvl_in;
    end

endmodule

// File: rtl/gpio_irq_status.sv
// Module: gpio_irq_status
// Sticky interrupt status bit. Any set (hardware or software) outranks a
// same-cycle clear.
// Assumes: sw_set/sw_clr are already qualified by the write strobe.
module gpio_irq_status (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic sw_set,
    input  logic sw_clr,
    output logic sts
);

    // Update status: set beats clear, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                sts <= 1'b0;
        else if (hw_set || sw_set) sts <= 1'b1;
        else if (sw_clr)           sts <= 1'b0;
    end

    // R6: a capture or software set always leaves status high.
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set || sw_set) |=> sts);

    // R4: an uncontested clear drops status.
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr && !hw_set && !sw_set) |=> !sts);

    // R2: with no command and no capture, status is held.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_clr && !hw_set && !sw_set) |=> $stable(sts));

endmodule

// File: rtl/gpio_irq_enable.sv
// Module: gpio_irq_enable
// Register-side interrupt enable flag with separate set and clear
// commands; set wins when both arrive together.
// Assumes: set/clr are already qualified by the write strobe.
module gpio_irq_enable (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic ena
);

    // Update enable flag: set beats clear, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)   ena <= 1'b0;
        else if (set) ena <= 1'b1;
        else if (clr) ena <= 1'b0;
    end

    // R7: set command turns the flag on.
    p_ena_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> ena);

    // R7: a lone clear command turns the flag off.
    p_ena_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !ena);

    // R10: without a command the flag is held.
    p_ena_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!set && !clr) |=> $stable(ena));

endmodule

// File: rtl/gpio_line_irq.sv
// Module: gpio_line_irq (top)
// Interrupt capture for one GPIO line: decodes the write-one command
// bits, keeps status and enable, forms the read word and the level
// request toward the line's message-signalled vector.
// Assumes: REG_W >= 4; bus address decode is done outside.
module gpio_line_irq
    import gpio_irq_pkg::*;
#(
    parameter int unsigned REG_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl_in,
    input  logic             cfg_int_en,
    input  logic             cfg_edge,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             irq_req
);

    localparam int unsigned PAD_W = REG_W - MIN_REG_W;

    irq_cmd_t cmd;
    logic     hw_set;
    logic     sts;
    logic     ena;

    // Decode write-one commands, qualified by the write strobe.
    always_comb begin
        cmd.sts_clr = wr_en & wr_data[STS_CLR_BIT];
        cmd.sts_set = wr_en & wr_data[STS_SET_BIT];
        cmd.ena_clr = wr_en & wr_data[ENA_CLR_BIT];
        cmd.ena_set = wr_en & wr_data[ENA_SET_BIT];
    end

    gpio_irq_trigger u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_in    (lvl_in),
        .edge_mode (cfg_edge),
        .hw_set    (hw_set)
    );

    gpio_irq_status u_sts (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_set (hw_set),
        .sw_set (cmd.sts_set),
        .sw_clr (cmd.sts_clr),
        .sts    (sts)
    );

    gpio_irq_enable u_ena (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (cmd.ena_set),
        .clr   (cmd.ena_clr),
        .ena   (ena)
    );

    // Assemble the read word: status and enable at fixed positions.
    always_comb begin
        rd_data             = '0;
        rd_data[RD_STS_BIT] = sts;
        rd_data[RD_ENA_BIT] = ena;
    end

    // Level request toward the vector: fully gated status.
    always_comb begin
        irq_req = sts & ena & cfg_int_en;
    end

    // R8: configuration enable low blocks the request.
    p_cfg_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_int_en |-> !irq_req);

    // R8: request only while the enable flag is set.
    p_flag_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> rd_data[RD_ENA_BIT]);

    // R2: in edge mode status can only rise after a rise of the level or a software set.
    p_edge_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sts) && $past(cfg_edge)) |-> ($past(lvl_in) || $past(cmd.sts_set)));

endmodule

// File: tb/gpio_line_irq_tb.sv
// Bench for gpio_line_irq: behavioural reference model compared every
// cycle, plus directed checks tagged by requirement.
module gpio_line_irq_tb;

    localparam int  CLK_PER = 10;
    localparam int  REG_W   = 64;
    localparam int  WDOG    = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lvl_in = 1'b0;
    logic             cfg_int_en = 1'b1;
    logic             cfg_edge = 1'b1;
    logic             wr_en = 1'b0;
    logic [REG_W-1:0] wr_data = '0;
    logic [REG_W-1:0] rd_data;
    logic             irq_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model state.
    int m_prev = 0;
    int m_sts  = 0;
    int m_ena  = 0;

    gpio_line_irq #(.REG_W(REG_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_in     (lvl_in),
        .cfg_int_en (cfg_int_en),
        .cfg_edge   (cfg_edge),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .irq_req    (irq_req)
    );

    always #(CLK_PER/2) clk = ~clk;

    task automatic check(input string req, input logic [REG_W-1:0] act,
                         input logic [REG_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Model update on each edge, then compare a quarter period later.
    always begin
        @(posedge clk);
        if (!rst_n) begin
            m_prev = 0; m_sts = 0; m_ena = 0;
        end else begin
            int cap;
            int wc, ws, ec, es;
            cap = cfg_edge ? (lvl_in && !m_prev) : int'(lvl_in);
            wc = wr_en && wr_data[0];
            ws = wr_en && wr_data[1];
            ec = wr_en && wr_data[2];
            es = wr_en && wr_data[3];
            if (cap || ws)  m_sts = 1;
            else if (wc)    m_sts = 0;
            if (es)         m_ena = 1;
            else if (ec)    m_ena = 0;
            m_prev = lvl_in;
        end
        #(CLK_PER/4);
        if (!done) begin
            logic [REG_W-1:0] exp_rd;
            exp_rd    = '0;
            exp_rd[0] = (m_sts != 0);
            exp_rd[3] = (m_ena != 0);
            check("R9 model read word", rd_data, exp_rd);
            check("R8 model request", {63'b0, irq_req},
                  {63'b0, (m_sts != 0) && (m_ena != 0) && cfg_int_en});
        end
    end

    // Drive one cycle of stimulus at the falling edge, return after the
    // next rising edge plus a quarter period.
    task automatic step(input logic lvl, input logic we, input logic [REG_W-1:0] wd);
        @(negedge clk);
        lvl_in  = lvl;
        wr_en   = we;
        wr_data = wd;
        @(posedge clk);
        #(CLK_PER/4);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        for (int i = 0; i < WDOG; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_PER/4);
        check("R1 reset read word", rd_data, '0);
        check("R1 reset request", {63'b0, irq_req}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // Edge mode.
        step(0, 0, 0);
        step(0, 1, 64'h8);
        check("R7 enable set", rd_data, 64'h8);
        step(1, 0, 0);
        check("R2 rise captured", rd_data, 64'h9);
        check("R8 request on", {63'b0, irq_req}, 64'h1);
        step(1, 1, 64'h1);
        check("R4 clear with steady high level", rd_data, 64'h8);
        step(1, 0, 0);
        check("R2 steady level no recapture", rd_data, 64'h8);
        step(0, 0, 0);
        step(1, 1, 64'h1);
        check("R6 edge beats clear", rd_data, 64'h9);
        step(1, 1, 64'h1);
        cfg_int_en = 1'b0;
        step(1, 1, 64'h2);
        check("R5 software set", rd_data, 64'h9);
        check("R8 gated by config", {63'b0, irq_req}, 64'h0);
        step(1, 0, 0);
        cfg_int_en = 1'b1;
        #1;
        check("R8 ungated", {63'b0, irq_req}, 64'h1);
        step(1, 1, 64'h3);
        check("R5 set beats clear", rd_data, 64'h9);
        step(1, 0, 64'h5);
        check("R10 strobe low ignored", rd_data, 64'h9);

        // Level mode.
        cfg_edge = 1'b0;
        step(1, 1, 64'h1);
        check("R3 clear while high", rd_data, 64'h9);
        step(0, 1, 64'h1);
        check("R3 clear while low", rd_data, 64'h8);
        step(0, 0, 0);
        check("R3 low level no capture", rd_data, 64'h8);
        step(1, 0, 0);
        check("R3 high level capture", rd_data, 64'h9);
        step(0, 1, 64'hC);
        check("R7 enable set beats clear", rd_data, 64'h9);
        step(0, 1, 64'h5);
        check("R7 combined mask and ack", rd_data, 64'h0);
        check("R8 request off", {63'b0, irq_req}, 64'h0);
        step(0, 1, 64'hFFFF_FFFF_FFFF_FFF0);
        check("R9 upper bits ignored", rd_data, 64'h0);
        step(0, 0, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule